// File: doc/BRIEF.md
# Buffered Transmit Serializer with Underrun End-of-Packet

This block takes words from a host and turns them into a serial bit stream for a line encoder. The host writes a data word together with a bit count into a one-entry holding buffer. When the shift register is free, the word moves into it. The bits then leave least significant first, one per pulse of a bit-time strobe. When the holding buffer has been emptied into the shift register, a buffer-empty flag is raised, so the host can queue the next word while the current one is still on the line.

If the shift register finishes its last bit while the buffer is still empty, the block treats this as the end of the packet and raises an underrun flag. In the two differential line modes it then waits a programmable number of bit times and drives an end-of-packet pattern on the pair:

- In USB mode the pattern is two bit times of both legs low, then one bit time of the idle-J level.
- In 10Base-T mode the positive leg is held high for two bit times, after which the line returns to idle low.

A word loaded during the wait cancels the end of packet and transmission carries on. In the other modes no end-of-packet pattern is made.

Top module: `txSerializer`

## Requirements
- R1: After reset the outputs are as follows: `serActive`, `serBit`, `eopOn`, `eopLine`, `flags` and `irq` are all 0.
- R2: A load with `loadCount` from 1 to 16 stores the word and count in the buffer. While the shift register is empty and no end-of-packet pattern is being sent, the buffer moves into it on the next clock. The shift register then presents bit 0 first on `serBit`, with `serActive` high, and advances one bit on each `bitStrobe`. It becomes inactive after the counted number of bits.
- R3: A load whose `loadCount` is 0 or 17 to 31 is ignored: no bits are sent and no buffer-empty event occurs.
- R4: If the buffer is reloaded before the strobe that ends the last bit of the current word, the first bit of the new word is on the line for the very next bit time. There is no idle bit time and no underrun.
- R5: An underrun is the strobe that ends the last bit while the buffer is empty. In USB mode (`lineMode`=1) and 10Base-T mode (`lineMode`=2) it is followed by exactly UNDERRUN_BITS idle bit times and then the end-of-packet pattern with `eopOn` high.
- R6: The end-of-packet pattern shows `eopLine` (the positive leg; the negative leg is low throughout) as 0,0,1 over three bit times in USB mode, and as 1,1 over two bit times in 10Base-T mode. After that `eopOn` returns to 0.
- R7: With `lineMode` 0 or 3, an underrun produces no countdown and no end-of-packet pattern.
- R8: A valid load during the underrun countdown cancels the pending end of packet, and the new word is sent.
- R9: `flags[0]` (buffer moved to shift register) and `flags[1]` (underrun, in every mode) set only while `enBufEmpty` or `enUnderrun` respectively is high. They stay set until a 1 is written on the matching `flagClr` bit. `irq` is the OR of both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineMode | input | 2 | 0/3 plain, 1 USB, 2 10Base-T |
| bitStrobe | input | 1 | One-cycle pulse marking the end of each bit time |
| loadValid | input | 1 | Host write of the holding buffer |
| loadData | input | 16 | Word to send, bit 0 first |
| loadCount | input | 5 | Number of bits, 1 to 16 |
| enBufEmpty | input | 1 | Enable for the buffer-empty flag |
| enUnderrun | input | 1 | Enable for the underrun flag |
| flagClr | input | 2 | Write-one-to-clear strobes for the flags |
| serBit | output | 1 | Current serial data bit |
| serActive | output | 1 | A data bit is on the line |
| eopOn | output | 1 | End-of-packet pattern in progress |
| eopLine | output | 1 | Positive-leg level during end of packet |
| flags | output | 2 | Sticky flags: bit 0 buffer empty, bit 1 underrun |
| irq | output | 1 | Any flag set |

## Verification
Each result arrives a fixed number of cycles or bit times after its stimulus:

- **Loading and flags.** A load is registered at the next edge. If the shift register is idle, the transfer follows one edge later, and the buffer-empty flag rises at that same edge.
- **Data bits.** Each data bit stays on `serBit` until the strobe that ends it.
- **End of packet.** The first end-of-packet symbol is on the line during the (UNDERRUN_BITS+1)-th strobe after the strobe that ended the last data bit.

The monitor therefore samples the outputs only on the falling clock edge inside a strobe cycle, when every registered output has settled. Each symbol seen there is compared with the next entry of the expected queue, including the number of idle strobes that must come before it.

// File: rtl/txSerPkg.sv
package txSerPkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_USB   = 2'd1,
    MODE_ETH   = 2'd2,
    MODE_ALT   = 2'd3
  } lineMode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_EOP   = 2'd2
  } txPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doTransfer;
    logic doShift;
  } serStrobe_t;

endpackage

// File: rtl/txSerData.sv
module txSerData
  import txSerPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  input  logic [CNT_W-1:0]  loadCount,
  input  serStrobe_t        strobe,
  output logic              bufFull,
  output logic [CNT_W-1:0]  shCnt,
  output logic              serBit
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);

  logic [DATA_W-1:0] bufData;
  logic [CNT_W-1:0]  bufCnt;
  logic [DATA_W-1:0] shReg;
  logic              loadOk;

  assign loadOk = loadValid && (loadCount != '0) && (loadCount <= MAX_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
      bufCnt  <= '0;
      bufFull <= 1'b0;
    end else if (loadOk) begin
      bufData <= loadData;
      bufCnt  <= loadCount;
      bufFull <= 1'b1;
    end else if (strobe.doTransfer) begin
      bufFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      shCnt <= '0;
    end else if (strobe.doTransfer) begin
      shReg <= bufData;
      shCnt <= bufCnt;
    end else if (strobe.doShift) begin
      shReg <= {1'b0, shReg[DATA_W-1:1]};
      shCnt <= shCnt - 1'b1;
    end
  end

  assign serBit = shReg[0] & (shCnt != '0);

  // an invalid count must not fill an empty buffer
  AST_BAD_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !loadOk && !bufFull) |=> !bufFull); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doTransfer |=> (shCnt != '0) && (shCnt <= MAX_CNT)); // R2

endmodule

// File: rtl/txSerCtrl.sv
module txSerCtrl
  import txSerPkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int UNDERRUN_BITS = 8,
  localparam int DOWN_W       = $clog2(UNDERRUN_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       lineMode,
  input  logic             bitStrobe,
  input  logic             bufFull,
  input  logic [CNT_W-1:0] shCnt,
  input  logic             enBufEmpty,
  input  logic             enUnderrun,
  input  logic [1:0]       flagClr,
  output serStrobe_t       strobe,
  output logic             eopOn,
  output logic             eopLine,
  output logic [1:0]       flags
);

  localparam logic [DOWN_W-1:0] DOWN_LOAD = DOWN_W'(UNDERRUN_BITS);

  txPhase_e          phase;
  logic [DOWN_W-1:0] downCnt;
  logic [1:0]        eopIdx;
  logic [1:0]        eopLast;
  logic              shBusy, lastStrobe, underrunEvt;
  logic              isUsb, eopMode;
  logic              flagBe, flagUr;

  assign isUsb   = lineMode_e'(lineMode) == MODE_USB;
  assign eopMode = isUsb || (lineMode_e'(lineMode) == MODE_ETH);
  assign eopLast = isUsb ? 2'd2 : 2'd1;

  assign shBusy      = shCnt != '0;
  assign lastStrobe  = bitStrobe && (shCnt == CNT_W'(1));
  assign underrunEvt = lastStrobe && !bufFull;

  always_comb begin
    strobe            = '0;
    strobe.doShift    = bitStrobe && shBusy;
    strobe.doTransfer = bufFull && ((!shBusy && phase != PH_EOP) || lastStrobe);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      downCnt <= '0;
      eopIdx  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (underrunEvt && eopMode) begin
            phase   <= PH_COUNT;
            downCnt <= DOWN_LOAD;
          end
        end
        PH_COUNT: begin
          if (strobe.doTransfer) begin
            phase <= PH_IDLE;
          end else if (bitStrobe) begin
            downCnt <= downCnt - 1'b1;
            if (downCnt == DOWN_W'(1)) begin
              phase  <= PH_EOP;
              eopIdx <= '0;
            end
          end
        end
        PH_EOP: begin
          if (bitStrobe) begin
            if (eopIdx >= eopLast) phase <= PH_IDLE;
            else                   eopIdx <= eopIdx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign eopOn   = phase == PH_EOP;
  assign eopLine = eopOn && (!isUsb || eopIdx == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagBe <= 1'b0;
      flagUr <= 1'b0;
    end else begin
      flagBe <= (flagBe && !flagClr[0]) || (strobe.doTransfer && enBufEmpty);
      flagUr <= (flagUr && !flagClr[1]) || (underrunEvt && enUnderrun);
    end
  end

  assign flags = {flagUr, flagBe};

  AST_SEAMLESS_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (lastStrobe && bufFull) |=> shCnt != '0); // R4

  AST_UNDERRUN_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (underrunEvt && eopMode) |=> (phase == PH_COUNT) && (downCnt == DOWN_LOAD)); // R5

  AST_PLAIN_NO_EOP: assert property (@(posedge clk) disable iff (!rstN)
    (underrunEvt && !eopMode) |=> phase == PH_IDLE); // R7

  AST_EOP_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    eopOn |-> shCnt == '0); // R6

  AST_LOAD_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COUNT && strobe.doTransfer) |=> phase == PH_IDLE); // R8

  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> $past(enBufEmpty)); // R9

endmodule

// File: rtl/txSerializer.sv
module txSerializer
  import txSerPkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int UNDERRUN_BITS = 8,
  localparam int CNT_W        = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        lineMode,
  input  logic              bitStrobe,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic              enBufEmpty,
  input  logic              enUnderrun,
  input  logic [1:0]        flagClr,
  output logic              serBit,
  output logic              serActive,
  output logic              eopOn,
  output logic              eopLine,
  output logic [1:0]        flags,
  output logic              irq
);

  serStrobe_t       strobe;
  logic             bufFull;
  logic [CNT_W-1:0] shCnt;

  txSerData #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadData(loadData),
    .loadCount(loadCount), .strobe(strobe), .bufFull(bufFull),
    .shCnt(shCnt), .serBit(serBit)
  );

  txSerCtrl #(.CNT_W(CNT_W), .UNDERRUN_BITS(UNDERRUN_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineMode(lineMode), .bitStrobe(bitStrobe),
    .bufFull(bufFull), .shCnt(shCnt), .enBufEmpty(enBufEmpty),
    .enUnderrun(enUnderrun), .flagClr(flagClr), .strobe(strobe),
    .eopOn(eopOn), .eopLine(eopLine), .flags(flags)
  );

  assign serActive = shCnt != '0;
  assign irq       = |flags;

endmodule

// File: tb/txSerializer_tb.sv
module txSerializer_tb;

  localparam int GAP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  lineMode = 2'd1;
  logic        bitStrobe = 1'b0;
  logic        loadValid = 1'b0;
  logic [15:0] loadData = '0;
  logic [4:0]  loadCount = '0;
  logic        enBufEmpty = 1'b1, enUnderrun = 1'b1;
  logic [1:0]  flagClr = '0;
  logic        serBit, serActive, eopOn, eopLine, irq;
  logic [1:0]  flags;

  int total = 0, bad = 0, cyc = 0, divCnt = 0, idleRun = 0;
  int expSym[$];
  int expGap[$];
  string expReq[$];

  txSerializer u_dut (
    .clk(clk), .rstN(rstN), .lineMode(lineMode), .bitStrobe(bitStrobe),
    .loadValid(loadValid), .loadData(loadData), .loadCount(loadCount),
    .enBufEmpty(enBufEmpty), .enUnderrun(enUnderrun), .flagClr(flagClr),
    .serBit(serBit), .serActive(serActive), .eopOn(eopOn), .eopLine(eopLine),
    .flags(flags), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    divCnt <= (divCnt == 3) ? 0 : divCnt + 1;
    bitStrobe <= (divCnt == 2);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: symbols 0/1 data, 2 eop low, 3 eop high
  always @(negedge clk) begin
    if (rstN && bitStrobe) begin
      if (serActive || eopOn) begin
        int sym;
        sym = serActive ? int'(serBit) : 2 + int'(eopLine);
        if (expSym.size() == 0) begin
          check(1'b0, "R7 unexpected symbol", sym, -1);
        end else begin
          int e, g;
          string rq;
          e = expSym.pop_front();
          g = expGap.pop_front();
          rq = expReq.pop_front();
          check(sym == e, rq, sym, e);
          if (g >= 0) check(idleRun == g, {rq, " idle gap"}, idleRun, g);
        end
        idleRun = 0;
      end else begin
        idleRun++;
      end
    end
  end

  task automatic push(input int s, input int g, input string rq);
    expSym.push_back(s);
    expGap.push_back(g);
    expReq.push_back(rq);
  endtask

  task automatic loadWord(input logic [15:0] d, input int n, input int firstGap);
    @(negedge clk);
    loadValid = 1'b1; loadData = d; loadCount = 5'(n);
    @(negedge clk);
    loadValid = 1'b0;
    for (int i = 0; i < n; i++) push(int'(d[i]), (i == 0) ? firstGap : -1, "R2 data bit");
  endtask

  task automatic expectEop(input bit usb);
    if (usb) begin
      push(2, GAP, "R5 usb eop start"); push(2, -1, "R6 usb se0");
      push(3, -1, "R6 usb J");
    end else begin
      push(3, GAP, "R5 eth eop start"); push(3, -1, "R6 eth high");
    end
  endtask

  task automatic waitStrobes(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (bitStrobe) k++;
    end
  endtask

  task automatic waitFlag(input int b);
    int t = 0;
    while (!flags[b] && t < 2000) begin @(negedge clk); t++; end
    check(flags[b] == 1'b1, "R9 flag set", int'(flags[b]), 1);
  endtask

  task automatic clearFlags();
    @(negedge clk); flagClr = 2'b11;
    @(negedge clk); flagClr = 2'b00;
  endtask

  task automatic drain();
    int t = 0;
    while (expSym.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    check(expSym.size() == 0, "R5 all expected symbols seen", expSym.size(), 0);
    waitStrobes(4);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(serActive == 0 && serBit == 0, "R1 serial idle", int'(serActive), 0);
    check(eopOn == 0 && eopLine == 0, "R1 eop idle", int'(eopOn), 0);
    check(flags == 0 && irq == 0, "R1 flags clear", int'(flags), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // USB: two words back to back, then underrun and EOP
    lineMode = 2'd1;
    loadWord(16'hA5C3, 16, -1);
    waitFlag(0);
    check(irq == 1'b1, "R9 irq follows flag", int'(irq), 1);
    clearFlags();
    check(flags[0] == 1'b0, "R9 write one clears", int'(flags[0]), 0);
    loadWord(16'h0005, 3, 0); // R4 no idle bit between words
    expectEop(1'b1);
    drain();
    check(flags[1] == 1'b1, "R5 underrun flag", int'(flags[1]), 1);
    clearFlags();
    check(irq == 1'b0, "R9 irq low after clear", int'(irq), 0);

    // 10Base-T, single-bit word
    lineMode = 2'd2;
    loadWord(16'h0001, 1, -1);
    expectEop(1'b0);
    drain();
    waitStrobes(3);
    check(eopOn == 1'b0, "R6 eth line back to idle", int'(eopOn), 0);
    clearFlags();

    // plain modes: underrun flag only, no EOP
    for (int m = 0; m < 4; m += 3) begin
      lineMode = 2'(m);
      loadWord(16'h0003, 2, -1);
      drain();
      waitStrobes(GAP + 6);
      check(flags[1] == 1'b1, "R7 underrun flag in plain mode", int'(flags[1]), 1);
      check(expSym.size() == 0 && eopOn == 0, "R7 no eop", int'(eopOn), 0);
      clearFlags();
    end

    // invalid counts ignored
    lineMode = 2'd1;
    @(negedge clk); loadValid = 1'b1; loadData = 16'hFFFF; loadCount = 5'd0;
    @(negedge clk); loadCount = 5'd17;
    @(negedge clk); loadValid = 1'b0;
    waitStrobes(6);
    check(serActive == 1'b0, "R3 nothing sent", int'(serActive), 0);
    check(flags[0] == 1'b0, "R3 no transfer event", int'(flags[0]), 0);

    // load during countdown cancels EOP
    loadWord(16'h00F6, 8, -1);
    waitFlag(1);
    waitStrobes(3);
    loadWord(16'h000A, 4, -1); // R8 resumes with no EOP between
    expectEop(1'b1);
    drain();
    clearFlags();

    // flags gated by enables
    enBufEmpty = 1'b0; enUnderrun = 1'b0;
    loadWord(16'h0002, 2, -1);
    expectEop(1'b1);
    drain();
    check(flags == 2'b00, "R9 disabled flags stay clear", int'(flags), 0);
    check(irq == 1'b0, "R9 irq stays low", int'(irq), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule